// File: doc/BRIEF.md
# Event Combiner and Interrupt Selector

This block is the interrupt front end of a processor subsystem. It captures 128 single-cycle event pulses into sticky flags, kept as four groups of 32. Event N sits in group N/32 at bit N mod 32. For each group it masks the flags and ORs the survivors into one combined event. A second, independent mask per group feeds a single exception line. Twelve selectors each pick one source for a CPU interrupt line, from line 4 up to line 15. The source is either a raw event flag or, for source numbers 0 to 3, the combined output of a group.

Software reaches every register over a 32-bit bus with word addresses and separate read and write strobes. A write takes effect at the clock edge where it is sampled. Read data appears on the cycle after the read strobe. Software can clear a flag by writing one to it, set a flag the same way, or raise a single event by number through an assert register.

Top module: `evc_top`

## Requirements
- R1: A one-cycle high on `evt_i[N]` sets flag bit N mod 32 of group N/32 at the next clock edge. The flag stays set until it is cleared.
- R2: The flag words of groups 0 to 3 are at word addresses 0 to 3. The set words are at 8 to 11 and the clear words at 16 to 19. A 1 written to a set word sets that flag bit, and a 1 written to a clear word clears it. Bits written as 0 leave their flags unchanged. Set and clear words read as 0.
- R3: The event mask words are at addresses 32 to 35, and a mask bit of 1 blocks its event. The read-only words at 40 to 43 return flag AND NOT mask for their group.
- R4: `comb_o[g]` is the OR of the masked-flag bits of group g.
- R5: The selector for output k is an 8-bit field at word 65 + k/4, bits (k mod 4)*8 and up. When the field holds a value from 4 to 127, `irq_o[k]` (CPU line k+4) is high exactly while the raw flag of that event is set.
- R6: A selector field holding a value g from 0 to 3 makes `irq_o[k]` follow `comb_o[g]`.
- R7: A selector field above 127 holds `irq_o[k]` low. Word 64 reads 0, and writes to it change nothing.
- R8: The exception mask words are at 48 to 51, and their read-only masked words are at 56 to 59 (flag AND NOT exception mask). `exc_o` is the OR of all masked exception bits.
- R9: Writing a value v below 128 to word 112 sets flag v. A value of 128 or more changes no flag.
- R10: If a clear write hits a flag bit in the same cycle as a new pulse on that event, the flag ends up set.
- R11: After reset, all flags are 0, every event mask bit and every exception mask bit is 1, and all selector fields are 0. Read data is valid in the cycle after `rd_en`. Addresses that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 128 | Single-cycle event pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| comb_o | output | 4 | Combined masked event per group |
| exc_o | output | 1 | Exception output |
| irq_o | output | 12 | Selected interrupts; bit k drives CPU line k+4 |

## Verification
All of the flag, mask and selector state can be seen at the ports, either through register reads or through `comb_o`, `irq_o` and `exc_o`. A flag that is wrongly set, lost or left uncleared shows on the routed outputs on the cycle after the edge that caused it. It also shows one read later in the flag and masked-flag words. A selector field that decodes wrongly drives the wrong line, or no line, as soon as the write edge has passed. The hardest case is a clear write that meets a new pulse on the same bit, since a lost event there leaves no trace other than the flag word.

// File: rtl/evc_pkg.sv
package evc_pkg;
    // Region codes: word address bits above the 3-bit group index
    localparam int RG_FLAG  = 0;
    localparam int RG_SET   = 1;
    localparam int RG_CLR   = 2;
    localparam int RG_MASK  = 4;
    localparam int RG_MFLAG = 5;
    localparam int RG_EXPM  = 6;
    localparam int RG_MEXP  = 7;
    localparam int RG_SEL   = 8;
    localparam int RG_ASRT  = 14;
endpackage

// File: rtl/evc_group.sv
module evc_group #(
    parameter int GW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] evt_i,
    input  logic [GW-1:0] set_i,
    input  logic [GW-1:0] clr_i,
    input  logic [GW-1:0] asrt_i,
    input  logic          mask_we,
    input  logic          expm_we,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] flag_o,
    output logic [GW-1:0] mask_o,
    output logic [GW-1:0] expm_o,
    output logic [GW-1:0] mflag_o,
    output logic [GW-1:0] mexp_o,
    output logic          comb_o,
    output logic          exc_o
);
    typedef struct packed {
        logic [GW-1:0] flag;
        logic [GW-1:0] mask;
        logic [GW-1:0] expm;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear applies to the old value; any new setter wins
        st_d.flag = (st_q.flag & ~clr_i) | set_i | asrt_i | evt_i;
        if (mask_we) st_d.mask = wdata;
        if (expm_we) st_d.expm = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.mask <= '1;
            st_q.expm <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign mask_o  = st_q.mask;
    assign expm_o  = st_q.expm;
    assign mflag_o = st_q.flag & ~st_q.mask;
    assign mexp_o  = st_q.flag & ~st_q.expm;
    assign comb_o  = |mflag_o;
    assign exc_o   = |mexp_o;
endmodule

// File: rtl/evc_route.sv
module evc_route #(
    parameter int NEVT  = 128,
    parameter int NCOMB = 4,
    parameter int SELW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SELW-1:0]  wdata,
    input  logic [NEVT-1:0]  flags,
    input  logic [NCOMB-1:0] comb,
    output logic [SELW-1:0]  sel_o,
    output logic             irq_o
);
    localparam int IW = $clog2(NEVT);
    localparam int CW = $clog2(NCOMB);
    localparam logic [SELW:0] EV_LIM = (SELW+1)'(NEVT);
    localparam logic [SELW:0] CB_LIM = (SELW+1)'(NCOMB);

    typedef struct packed {
        logic [SELW-1:0] sel;
    } rt_st_t;

    rt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.sel = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if ({1'b0, st_q.sel} < CB_LIM)
            irq_o = comb[st_q.sel[CW-1:0]];
        else if ({1'b0, st_q.sel} < EV_LIM)
            irq_o = flags[st_q.sel[IW-1:0]];
        else
            irq_o = 1'b0;
    end

    assign sel_o = st_q.sel;
endmodule

// File: rtl/evc_top.sv
module evc_top #(
    parameter int GROUPS = 4,
    parameter int GW     = 32,
    parameter int NOUT   = 12,
    parameter int SELW   = 8,
    parameter int AW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GROUPS*GW-1:0] evt_i,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr,
    input  logic [GW-1:0]        wdata,
    output logic [GW-1:0]        rdata,
    output logic [GROUPS-1:0]    comb_o,
    output logic                 exc_o,
    output logic [NOUT-1:0]      irq_o
);
    import evc_pkg::*;

    localparam int NEVT = GROUPS * GW;
    localparam int GIW  = $clog2(GROUPS);
    localparam int BW   = $clog2(GW);
    localparam int IW   = $clog2(NEVT);
    localparam int NPER = GW / SELW;
    localparam int RW   = AW - 3;

    logic [RW-1:0] region;
    logic [2:0]    idx;
    logic          gvalid;
    logic [GIW-1:0] gi;

    assign region = addr[AW-1:3];
    assign idx    = addr[2:0];
    assign gvalid = idx < 3'(GROUPS);
    assign gi     = idx[GIW-1:0];

    logic [GW-1:0] flag_a  [GROUPS];
    logic [GW-1:0] mask_a  [GROUPS];
    logic [GW-1:0] expm_a  [GROUPS];
    logic [GW-1:0] mflag_a [GROUPS];
    logic [GW-1:0] mexp_a  [GROUPS];
    logic [GROUPS-1:0] exc_g;
    logic [NEVT-1:0]   flags_all;
    logic [SELW-1:0]   sel_a [NOUT];

    // event-assert decode
    logic          asrt_ok;
    logic [IW-BW-1:0] asrt_grp;
    logic [GW-1:0] asrt_vec;

    assign asrt_ok  = wr_en && (region == RW'(RG_ASRT)) && (idx == 3'd0)
                      && (wdata < GW'(NEVT));
    assign asrt_grp = wdata[IW-1:BW];
    assign asrt_vec = GW'(1) << wdata[BW-1:0];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (idx == 3'(g));
        evc_group #(.GW(GW)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[g*GW +: GW]),
            .set_i   ((hit && region == RW'(RG_SET)) ? wdata : '0),
            .clr_i   ((hit && region == RW'(RG_CLR)) ? wdata : '0),
            .asrt_i  ((asrt_ok && asrt_grp == (IW-BW)'(g)) ? asrt_vec : '0),
            .mask_we (hit && region == RW'(RG_MASK)),
            .expm_we (hit && region == RW'(RG_EXPM)),
            .wdata   (wdata),
            .flag_o  (flag_a[g]),
            .mask_o  (mask_a[g]),
            .expm_o  (expm_a[g]),
            .mflag_o (mflag_a[g]),
            .mexp_o  (mexp_a[g]),
            .comb_o  (comb_o[g]),
            .exc_o   (exc_g[g])
        );
        assign flags_all[g*GW +: GW] = flag_a[g];
    end

    assign exc_o = |exc_g;

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        evc_route #(.NEVT(NEVT), .NCOMB(GROUPS), .SELW(SELW)) u_rt (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && region == RW'(RG_SEL) && idx == 3'(k/NPER + 1)),
            .wdata (wdata[(k%NPER)*SELW +: SELW]),
            .flags (flags_all),
            .comb  (comb_o),
            .sel_o (sel_a[k]),
            .irq_o (irq_o[k])
        );
    end

    // packed selector word for readback
    logic [GW-1:0] sel_word;
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NOUT; k++) begin
            if (idx == 3'(k/NPER + 1))
                sel_word[(k%NPER)*SELW +: SELW] = sel_a[k];
        end
    end

    typedef struct packed {
        logic [GW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (rd_en) begin
            case (region)
                RW'(RG_FLAG):  if (gvalid) st_d.rdata = flag_a[gi];
                RW'(RG_MASK):  if (gvalid) st_d.rdata = mask_a[gi];
                RW'(RG_MFLAG): if (gvalid) st_d.rdata = mflag_a[gi];
                RW'(RG_EXPM):  if (gvalid) st_d.rdata = expm_a[gi];
                RW'(RG_MEXP):  if (gvalid) st_d.rdata = mexp_a[gi];
                RW'(RG_SEL):   st_d.rdata = sel_word;
                default:       st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int GROUPS = 4,
    parameter int GW     = 32,
    parameter int NOUT   = 12,
    parameter int AW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [GROUPS*GW-1:0] evt_i,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic [GW-1:0]        wdata,
    input logic [GROUPS-1:0]    comb_o,
    input logic                 exc_o,
    input logic [NOUT-1:0]      irq_o,
    input logic [GROUPS*GW-1:0] flags_all
);
    localparam int GIW = $clog2(GROUPS);

    logic [GROUPS-1:0] grp_any;
    always_comb begin
        for (int g = 0; g < GROUPS; g++)
            grp_any[g] = |flags_all[g*GW +: GW];
    end

    // remember a clear write and the pulses that arrived with it
    logic           clr_hit;
    logic           hit_q;
    logic [GIW-1:0] grp_q;
    logic [GW-1:0]  cmask_q;
    logic [GW-1:0]  slice_q;

    assign clr_hit = wr_en && (addr[AW-1:3] == (AW-3)'(2)) && (addr[2:0] < 3'(GROUPS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            grp_q   <= '0;
            cmask_q <= '0;
        end else begin
            hit_q   <= clr_hit;
            grp_q   <= addr[GIW-1:0];
            cmask_q <= wdata & ~evt_i[addr[GIW-1:0]*GW +: GW];
        end
    end

    assign slice_q = flags_all[grp_q*GW +: GW];

    a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_all & $past(evt_i)) == $past(evt_i)));

    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> ((slice_q & cmask_q) == '0));

    a_r4_comb_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_o & ~grp_any) == '0);

    a_r8_exc_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (|flags_all));

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (|flags_all));
endmodule

bind evc_top evc_checker #(
    .GROUPS(GROUPS), .GW(GW), .NOUT(NOUT), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .comb_o    (comb_o),
    .exc_o     (exc_o),
    .irq_o     (irq_o),
    .flags_all (flags_all)
);

// File: tb/evc_top_tb.sv
module evc_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_i = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [3:0]   comb_o;
    logic         exc_o;
    logic [11:0]  irq_o;

    always #5 clk = ~clk;

    evc_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .comb_o(comb_o),
        .exc_o(exc_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic rd_seen = 1'b0;
    bit   done = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: read data lands one cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            if (q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R11: unexpected read data %h expected none", rdata);
            end else begin
                e = q.pop_front();
                check(rdata, e.d, e.tag);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.d = exp; e.tag = tag;
        q.push_back(e);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        evt_i[n] = 1'b1;
        @(negedge clk);
        evt_i[n] = 1'b0;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check({20'd0, irq_o}, 32'h0, "R11 irq after reset");
        check({28'd0, comb_o}, 32'h0, "R11 comb after reset");
        check({31'd0, exc_o}, 32'h0, "R11 exc after reset");
        rd(8'd32, 32'hFFFF_FFFF, "R11 mask0 reset");
        rd(8'd51, 32'hFFFF_FFFF, "R11 expm3 reset");
        rd(8'd0,  32'h0, "R11 flag0 reset");
        rd(8'd66, 32'h0, "R11 selector reset");

        // R1 pulse on event 40 -> group 1 bit 8
        pulse(40);
        rd(8'd1, 32'h0000_0100, "R1 flag1 after pulse");

        // R2 set/clear
        wr(8'd10, 32'h5);
        rd(8'd2, 32'h5, "R2 set group2");
        wr(8'd18, 32'h1);
        rd(8'd2, 32'h4, "R2 clear group2 bit0 only");
        rd(8'd9, 32'h0, "R2 set word reads zero");

        // R3/R4 mask and combined
        wr(8'd33, ~32'h100);
        rd(8'd41, 32'h100, "R3 masked flag1");
        rd(8'd40, 32'h0, "R3 masked flag0");
        check({28'd0, comb_o}, 32'h2, "R4 comb after unmask");

        // R5/R6/R7 selectors: out0=40, out1=1, out2=200, out3=0
        wr(8'd65, 32'h00C8_0128);
        check({20'd0, irq_o}, 32'h003, "R5 R6 R7 irq routing");
        rd(8'd65, 32'h00C8_0128, "R5 selector readback");
        wr(8'd64, 32'hFFFF_FFFF);
        rd(8'd64, 32'h0, "R7 unused selector word");
        check({20'd0, irq_o}, 32'h003, "R7 unused word write no effect");

        // R6 combined path drops when masked again
        wr(8'd33, 32'hFFFF_FFFF);
        check({28'd0, comb_o}, 32'h0, "R4 comb after mask");
        check({20'd0, irq_o}, 32'h001, "R6 irq follows comb");

        // R8 exception
        wr(8'd50, 32'hFFFF_FFFB);
        check({31'd0, exc_o}, 32'h1, "R8 exc raised");
        rd(8'd58, 32'h4, "R8 masked exception group2");
        wr(8'd50, 32'hFFFF_FFFF);
        check({31'd0, exc_o}, 32'h0, "R8 exc masked");

        // R9 event assert
        wr(8'd112, 32'd100);
        rd(8'd3, 32'h10, "R9 assert event 100");
        wr(8'd112, 32'd130);
        rd(8'd0, 32'h0, "R9 out-of-range group0");
        rd(8'd3, 32'h10, "R9 out-of-range group3");
        rd(8'd2, 32'h4, "R9 out-of-range group2");

        // R10 pulse and clear same cycle on event 70 (group2 bit6)
        evt_i[70] = 1'b1;
        wr(8'd18, 32'h40);
        evt_i[70] = 1'b0;
        rd(8'd2, 32'h44, "R10 pulse wins over clear");
        wr(8'd67, 32'h4600_0000);
        check({20'd0, irq_o}, 32'h801, "R5 out11 routes event 70");
        rd(8'd67, 32'h4600_0000, "R5 top field position");
        wr(8'd18, 32'h40);
        check({20'd0, irq_o}, 32'h001, "R2 clear drops out11");
        rd(8'd2, 32'h4, "R2 clear bit6");
        rd(8'd7, 32'h0, "R11 unmapped group index");

        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11: actual %0d pending reads expected 0", q.size());
        end
        finish_up();
    end
endmodule